// File: doc/BRIEF.md
# Software-loaded set-associative TLB with reference/change tracking

This block is a translation buffer that software fills. It keeps a separate half for instruction fetches and a half for data accesses. Each entry holds an effective page number and two page-table words. The first word carries a valid bit, a hash-select bit and a compare field. The second word carries the real page number, the reference and change flags and a two-bit permission code.

A lookup presents an effective address, a compare tag from segment translation, a protection key and the access kind. Within one cycle the block selects a set from the low page-number bits and examines every way of that set. It reports one of three outcomes: hit, protection violation or miss. For a hit or a violation it also gives the real address, the protection granted and the selected second word.

On the following clock edge the block writes the reference and change flags back into the selected entry. On a miss it keeps the effective address and the compare tag, so that a refill handler can read them. A separate write port loads whole entries. Walking the hashed page table in memory is left to software.

Top module: `soft_tlb`

## Requirements
- R1: The entry is addressed by half (instruction or data), way and set. The set is page-number bits [SET_W-1:0], which is address bits [16:12] at the default parameters. A lookup with `lk_instr`=1 searches only entries written with `wr_instr`=1, and a lookup with `lk_instr`=0 searches only entries written with `wr_instr`=0.
- R2: A way takes part in the search only when its stored page number equals `lk_ea[31:12]` in full. Another page that maps to the same set does not match.
- R3: A way matches only when all three of these hold: its first word has bit 31 (valid) set, its first word has bit 6 (hash select) clear, and its first word equals `lk_tag` on the bits of mask 0x7FFFFFBF.
- R4: The permission code is bits [1:0] of the second word. `lk_prot` bit 0 means read and bit 1 means write. With key 0, codes 0, 1 and 2 give read/write and code 3 gives read only. With key 1, code 0 gives nothing, codes 1 and 3 give read only and code 2 gives read/write. A store needs write permission. A load or a fetch needs read permission.
- R5: Ways are examined from way 0 upward. The first way that grants the access ends the search and is selected. A way that refuses the access is remembered and the search goes on. A later refusing way replaces an earlier one. A grant from any later way takes precedence over a remembered refusal.
- R6: While `lk_valid` is high, exactly one of `lk_hit`, `lk_viol` and `lk_miss` is high. While it is low, none of them is high. On a hit or a violation, `lk_raddr` is {second word[31:12], `lk_ea`[11:0]} and `lk_pte1` is the selected second word as it was before this lookup. On a miss, `lk_raddr`, `lk_pte1` and `lk_prot` are zero.
- R7: After a hit or a violation, bit 8 (0x100, reference) of the selected entry's second word is set at the next clock edge. Ways that were not selected are left unchanged.
- R8: If bit 7 (0x080, change) of the selected second word is clear, it is set at the next edge only for a store that was granted. For any other access the reported write permission is cleared for this lookup.
- R9: On a miss, `miss_ea` and `miss_tag` take `lk_ea` and `lk_tag` at the next edge. They hold their values at all other times.
- R10: Reset clears every entry and both capture registers, so every lookup after reset misses.
- R11: `wr_en` writes the page number and both words into the addressed entry at the next edge. When the same entry is also due a flag write-back in that cycle, the loaded values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load an entry |
| wr_instr | input | 1 | Load into the instruction half |
| wr_way | input | WAY_W | Way to load |
| wr_epn | input | 32-PAGE_BITS | Page number; low bits select the set |
| wr_pte0 | input | 32 | First page-table word |
| wr_pte1 | input | 32 | Second page-table word |
| lk_valid | input | 1 | Lookup request |
| lk_instr | input | 1 | Lookup is an instruction fetch |
| lk_store | input | 1 | Lookup is a store |
| lk_key | input | 1 | Protection key from the segment |
| lk_ea | input | 32 | Effective address |
| lk_tag | input | 32 | Compare tag from segment translation |
| lk_hit | output | 1 | Access granted |
| lk_viol | output | 1 | Matching entry refuses the access |
| lk_miss | output | 1 | No matching entry |
| lk_prot | output | 2 | Reported protection {write, read} |
| lk_raddr | output | 32 | Real address |
| lk_pte1 | output | 32 | Selected second word before update |
| miss_ea | output | 32 | Address of the last miss |
| miss_tag | output | 32 | Compare tag of the last miss |

## Verification
The bench builds the block with its default parameters: two ways, 32 sets per half and 4 KiB pages. Because there are only 32 sets, pages such as 0x12345, 0x20005 and 0x32345 fall into the same set. This lets the bench test page-number mismatch and the use of both ways inside one set. Two ways are enough to reach a violation followed by a grant, and two violations in a row. Because flags are written back in a one-cycle window, the sequence of vectors can observe them on the next lookup.

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int WAYS      = 2,
  parameter int SETS      = 32,
  parameter int PAGE_BITS = 12,
  localparam int EPN_W = 32 - PAGE_BITS,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int HALF  = WAYS * SETS,
  localparam int DEPTH = 2 * HALF,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_instr,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [EPN_W-1:0] wr_epn,
  input  logic [31:0]      wr_pte0,
  input  logic [31:0]      wr_pte1,
  input  logic             lk_valid,
  input  logic             lk_instr,
  input  logic             lk_store,
  input  logic             lk_key,
  input  logic [31:0]      lk_ea,
  input  logic [31:0]      lk_tag,
  output logic             lk_hit,
  output logic             lk_viol,
  output logic             lk_miss,
  output logic [1:0]       lk_prot,
  output logic [31:0]      lk_raddr,
  output logic [31:0]      lk_pte1,
  output logic [31:0]      miss_ea,
  output logic [31:0]      miss_tag
);
  localparam logic [31:0] TAG_MASK = 32'h7FFF_FFBF;
  localparam logic [31:0] REF_BIT  = 32'h0000_0100;
  localparam logic [31:0] CHG_BIT  = 32'h0000_0080;

  logic [EPN_W-1:0] epn_q  [DEPTH];
  logic [31:0]      pte0_q [DEPTH];
  logic [31:0]      pte1_q [DEPTH];

  function automatic logic [IDX_W-1:0] ent(logic instr, logic [WAY_W-1:0] way,
                                           logic [SET_W-1:0] set);
    return IDX_W'(instr) * IDX_W'(HALF) + IDX_W'(way) * IDX_W'(SETS) + IDX_W'(set);
  endfunction

  function automatic logic [1:0] pp_prot(logic key, logic [1:0] pp);
    if (!key) return (pp == 2'd3) ? 2'b01 : 2'b11;
    case (pp)
      2'd0:    return 2'b00;
      2'd2:    return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  logic [SET_W-1:0] lk_set;
  logic [EPN_W-1:0] lk_epn;
  assign lk_set = lk_ea[PAGE_BITS +: SET_W];
  assign lk_epn = lk_ea[31:PAGE_BITS];

  logic [WAYS-1:0] way_match, way_ok;
  logic [1:0]      way_prot [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [IDX_W-1:0] ix;
    logic [31:0]      p0, p1;
    assign ix = ent(lk_instr, WAY_W'(w), lk_set);
    assign p0 = pte0_q[ix];
    assign p1 = pte1_q[ix];
    assign way_match[w] = (epn_q[ix] == lk_epn) && p0[31] && !p0[6] &&
                          ((p0 & TAG_MASK) == (lk_tag & TAG_MASK));
    assign way_prot[w]  = pp_prot(lk_key, p1[1:0]);
    assign way_ok[w]    = lk_store ? way_prot[w][1] : way_prot[w][0];
  end

  logic             sel_found, sel_ok;
  logic [WAY_W-1:0] sel_way;

  always_comb begin
    sel_found = 1'b0;
    sel_ok    = 1'b0;
    sel_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!sel_ok && way_match[w]) begin
        sel_found = 1'b1;
        sel_ok    = way_ok[w];
        sel_way   = WAY_W'(w);
      end
    end
  end

  logic [IDX_W-1:0] sel_idx;
  logic [31:0]      sel_pte1;
  logic             granted_store, keep_write, sel_live;

  assign sel_idx       = ent(lk_instr, sel_way, lk_set);
  assign sel_pte1      = pte1_q[sel_idx];
  assign sel_live      = lk_valid && sel_found;
  assign granted_store = lk_store && sel_ok;
  assign keep_write    = sel_pte1[7] || granted_store;

  assign lk_hit   = sel_live && sel_ok;
  assign lk_viol  = sel_live && !sel_ok;
  assign lk_miss  = lk_valid && !sel_found;
  assign lk_prot  = sel_live ? (way_prot[sel_way] & {keep_write, 1'b1}) : 2'b00;
  assign lk_raddr = sel_live ? {sel_pte1[31:PAGE_BITS], lk_ea[PAGE_BITS-1:0]} : 32'h0;
  assign lk_pte1  = sel_live ? sel_pte1 : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        epn_q[i]  <= '0;
        pte0_q[i] <= '0;
        pte1_q[i] <= '0;
      end
    end else begin
      if (sel_live)
        pte1_q[sel_idx] <= sel_pte1 | REF_BIT | (granted_store ? CHG_BIT : 32'h0);
      if (wr_en) begin
        epn_q[ent(wr_instr, wr_way, wr_epn[SET_W-1:0])]  <= wr_epn;
        pte0_q[ent(wr_instr, wr_way, wr_epn[SET_W-1:0])] <= wr_pte0;
        pte1_q[ent(wr_instr, wr_way, wr_epn[SET_W-1:0])] <= wr_pte1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_ea  <= '0;
      miss_tag <= '0;
    end else if (lk_miss) begin
      miss_ea  <= lk_ea;
      miss_tag <= lk_tag;
    end
  end
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic        lk_store,
  input logic [31:0] lk_ea,
  input logic [31:0] lk_tag,
  input logic        lk_hit,
  input logic        lk_viol,
  input logic        lk_miss,
  input logic [1:0]  lk_prot,
  input logic [31:0] lk_raddr,
  input logic [31:0] lk_pte1,
  input logic [31:0] miss_ea,
  input logic [31:0] miss_tag
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_viol, lk_miss}) == 1); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_viol || lk_miss)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_raddr == 32'h0 && lk_pte1 == 32'h0 && lk_prot == 2'b00)); // R6
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_viol) |-> lk_raddr[11:0] == lk_ea[11:0]); // R6
  AST_HIT_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_prot[0]); // R4
  AST_LOAD_VIOL_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_viol && !lk_store) |-> lk_prot == 2'b00); // R4
  AST_STORE_HIT_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_store) |-> lk_prot == 2'b11); // R8
  AST_CLEAN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_hit || lk_viol) && !lk_pte1[7] && !(lk_hit && lk_store)) |-> !lk_prot[1]); // R8
  AST_MISS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> (miss_ea == $past(lk_ea) && miss_tag == $past(lk_tag))); // R9
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_miss |=> ($stable(miss_ea) && $stable(miss_tag))); // R9
endmodule

bind soft_tlb soft_tlb_chk u_chk (.*);

// File: tb/tb_soft_tlb.sv
module tb_soft_tlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_instr = 0, wr_way = 0;
  logic [19:0] wr_epn = '0;
  logic [31:0] wr_pte0 = '0, wr_pte1 = '0;
  logic lk_valid = 0, lk_instr = 0, lk_store = 0, lk_key = 0;
  logic [31:0] lk_ea = '0, lk_tag = '0;
  logic lk_hit, lk_viol, lk_miss;
  logic [1:0] lk_prot;
  logic [31:0] lk_raddr, lk_pte1, miss_ea, miss_tag;

  always #4 clk = ~clk;

  soft_tlb dut (.*);

  localparam logic [31:0] T1 = 32'h0005_5E04;
  localparam logic [31:0] T2 = 32'h0000_8880;
  localparam logic [2:0] HIT = 3'b100, VIO = 3'b010, MIS = 3'b001;

  typedef struct packed {
    logic        instr, store, key;
    logic [31:0] ea, tag;
    logic [2:0]  res;
    logic [1:0]  prot;
    logic [31:0] raddr, pte1;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,32'h12345ABC,T1,HIT,2'b01,32'h55555ABC,32'h55555002}, // R4 R8 load, change clear
    '{0,1,0,32'h12345ABC,T1,HIT,2'b11,32'h55555ABC,32'h55555102}, // R7 R8 reference seen, store sets change
    '{0,0,0,32'h12345ABC,T1,HIT,2'b11,32'h55555ABC,32'h55555182}, // R8 change now set
    '{1,0,0,32'h12345010,T1,HIT,2'b11,32'h77777010,32'h77777181}, // R1 instruction half
    '{0,1,1,32'h20005FFF,T2,VIO,2'b01,32'h66666FFF,32'h66666003}, // R4 key1 code3 store refused
    '{0,0,1,32'h20005004,T2,HIT,2'b01,32'h66666004,32'h66666103}, // R7 reference set by violation
    '{0,0,0,32'h12345000,T2,MIS,2'b00,32'h0,32'h0},               // R3 tag mismatch
    '{0,0,0,32'h00006000,T2,MIS,2'b00,32'h0,32'h0},               // R3 hash-select bit set
    '{1,0,0,32'h20005000,T2,MIS,2'b00,32'h0,32'h0},               // R1 data entry invisible to fetch
    '{0,1,0,32'h00009000,T1,HIT,2'b11,32'h22222000,32'h22222002}, // R5 refusal then grant
    '{0,1,1,32'h0000A000,T1,VIO,2'b01,32'h44444000,32'h44444001}, // R5 last refusal kept
    '{0,0,1,32'h0000A008,T1,HIT,2'b01,32'h44444008,32'h44444101}, // R5 R7 way 1 flagged
    '{0,0,0,32'h0000A000,T1,HIT,2'b01,32'h33333000,32'h33333000}, // R5 R7 way 0 untouched
    '{0,0,0,32'h00009000,T1,HIT,2'b01,32'h11111000,32'h11111003}, // R5 R7 way 0 untouched
    '{0,0,0,32'h32345000,T1,MIS,2'b00,32'h0,32'h0}                // R2 same set, other page
  };

  int checks = 0, errors = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(logic ins, logic way, logic [19:0] epn, logic [31:0] p0, logic [31:0] p1);
    @(negedge clk);
    wr_en = 1; wr_instr = ins; wr_way = way; wr_epn = epn; wr_pte0 = p0; wr_pte1 = p1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(logic ins, logic st, logic key, logic [31:0] ea, logic [31:0] tag);
    @(negedge clk);
    lk_valid = 1; lk_instr = ins; lk_store = st; lk_key = key; lk_ea = ea; lk_tag = tag;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 0;
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 R9: empty after reset, capture registers zero
    look(0, 0, 0, 32'h12345000, T1);
    chk("R10", "miss after reset", {29'b0, lk_hit, lk_viol, lk_miss}, {29'b0, MIS});
    chk("R10", "miss_ea reset", miss_ea, 32'h0);
    chk("R10", "miss_tag reset", miss_tag, 32'h0);
    idle();
    chk("R6", "idle flags", {29'b0, lk_hit, lk_viol, lk_miss}, 32'h0);
    chk("R9", "miss_ea captured", miss_ea, 32'h12345000);

    load(0, 0, 20'h12345, 32'h80055E04, 32'h55555002);
    load(0, 1, 20'h20005, 32'h80008880, 32'h66666003);
    load(1, 0, 20'h12345, 32'h80055E04, 32'h77777181);
    load(0, 0, 20'h00006, 32'h800088C0, 32'h00000001);
    load(0, 0, 20'h00009, 32'h80055E04, 32'h11111003);
    load(0, 1, 20'h00009, 32'h80055E04, 32'h22222002);
    load(0, 0, 20'h0000A, 32'h80055E04, 32'h33333000);
    load(0, 1, 20'h0000A, 32'h80055E04, 32'h44444001);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i].instr, VEC[i].store, VEC[i].key, VEC[i].ea, VEC[i].tag);
      chk("R1-R8 vector", "outcome", {29'b0, lk_hit, lk_viol, lk_miss}, {29'b0, VEC[i].res});
      chk("R4 vector", "prot", {30'b0, lk_prot}, {30'b0, VEC[i].prot});
      chk("R6 vector", "raddr", lk_raddr, VEC[i].raddr);
      chk("R7 vector", "pte1", lk_pte1, VEC[i].pte1);
    end

    // R9: capture on miss, hold on hit
    look(0, 0, 0, 32'hDEAD0123, T1);
    chk("R9", "miss outcome", {31'b0, lk_miss}, 32'h1);
    look(0, 0, 0, 32'h12345ABC, T1);
    chk("R9", "hit outcome", {31'b0, lk_hit}, 32'h1);
    chk("R9", "miss_ea", miss_ea, 32'hDEAD0123);
    chk("R9", "miss_tag", miss_tag, T1);
    idle();
    chk("R9", "miss_ea held", miss_ea, 32'hDEAD0123);

    // R11: load wins over flag write-back to the same entry
    @(negedge clk);
    lk_valid = 1; lk_instr = 0; lk_store = 1; lk_key = 0; lk_ea = 32'h12345000; lk_tag = T1;
    wr_en = 1; wr_instr = 0; wr_way = 0; wr_epn = 20'h12345; wr_pte0 = 32'h80055E04; wr_pte1 = 32'h9999A002;
    #2;
    chk("R11", "pre-load hit", {31'b0, lk_hit}, 32'h1);
    @(negedge clk);
    wr_en = 0;
    lk_store = 0;
    #2;
    chk("R11", "loaded pte1", lk_pte1, 32'h9999A002);
    chk("R11", "loaded raddr", lk_raddr, 32'h9999A000);
    chk("R11", "loaded prot", {30'b0, lk_prot}, 32'h1);

    // R10: reset clears loaded entries
    idle();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    look(0, 0, 0, 32'h12345ABC, T1);
    chk("R10", "miss after second reset", {31'b0, lk_miss}, 32'h1);
    look(1, 0, 0, 32'h12345010, T1);
    chk("R10", "fetch miss after reset", {31'b0, lk_miss}, 32'h1);
    idle();

    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule